// File: doc/BRIEF.md
# Fixed-Priority Restart Vector Unit

This block takes four dedicated interrupt request lines into a small CPU and presents one of them at a time. It presents the highest-ranked request that is both pending and allowed. For that request it drives an interrupt-pending flag and a fixed 16-bit restart address. The CPU then fetches a jump from that address. The four addresses are fixed and not evenly spaced.

The top line is reserved for urgent events such as an early power-loss warning. No software setting can block it. To reject glitches, this line is accepted only when a rising edge is followed by the line still being high at the next clock edge. The second line latches on a rising edge and holds its request until it is serviced. The two bottom lines are level sensitive. A five-bit control register, written through a single-strobe port, holds three per-line mask bits and a global enable that gate the three lower lines. It also carries a self-clearing command bit that drops the second line's latch. An acknowledge input, carrying the index of the serviced line, clears that line's latch and no other.

Top module: `irqvec_unit`

## Requirements
- R1: After reset the three lower lines are all masked and the global enable is off, so with any levels on lines 1 and 0 the outputs stay at int_pend = 0 and vec_addr = 0x0000.
- R2: Priority from highest to lowest is line 3, line 2, line 1, line 0. Only the highest eligible request is presented.
- R3: While a request is presented, vec_addr is 0x0024 for line 3, 0x003C for line 2, 0x0034 for line 1 and 0x002C for line 0, and int_pend is 1.
- R4: Line 3 is accepted only after a low-to-high change seen at one clock edge with the line still high at the next edge. The request appears after that second edge. A high pulse seen at only one edge is discarded.
- R5: An accepted line 3 request is presented regardless of the mask bits and the global enable.
- R6: Line 2 latches on a rising edge seen at a clock edge and stays pending after the input falls. It clears on an acknowledge with index 2, or on a register write with bit 4 set.
- R7: Lines 1 and 0 are level sensitive. Their requests follow the inputs combinationally and are not latched.
- R8: Register bits 2, 1, 0 mask lines 2, 1, 0 respectively (1 = masked). A line 2 edge that arrives while the line is masked is still latched, and it is presented once the line is unmasked.
- R9: Register bit 3 is the global enable. When it is 0, lines 2 to 0 are not presented.
- R10: An acknowledge (ack_valid = 1 at a clock edge) clears only the latch of the line named by ack_idx (3 or 2). An acknowledge naming another line leaves both latches unchanged.
- R11: With nothing eligible, int_pend is 0 and vec_addr is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_in | input | 4 | Request lines; bit 3 urgent, bit 2 edge-latched, bits 1 and 0 level |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 5 | Bits 2..0 masks, bit 3 global enable, bit 4 clear line 2 latch |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | 2 | Index of the serviced line |
| int_pend | output | 1 | A request is being presented |
| vec_addr | output | 16 | Restart address of the presented request |

## Verification
The hardest state to reach is a line 2 latch that is set while the line is masked. From the outputs alone it cannot be told apart from no edge at all. The stimulus masks line 2, pulses it and drops it again, and checks that nothing is presented. It then clears the mask and expects 0x003C without any new edge. The glitch filter on line 3 is the other case that only timing can reach. A one-cycle pulse is driven and must leave no request. Then a held level is driven, and the request is checked both after the first edge (still absent) and after the second edge (present).

// File: rtl/irqvec_pkg.sv
package irqvec_pkg;
  localparam int NLINE   = 4;
  localparam int IDX_W   = $clog2(NLINE);
  localparam int VEC_W   = 16;
  localparam int NMASK   = NLINE - 1;
  localparam int CTRL_W  = NMASK + 2;
  localparam int EN_BIT  = NMASK;
  localparam int CLR_BIT = NMASK + 1;
  localparam int IDX_URG = NLINE - 1;
  localparam int IDX_EDG = NLINE - 2;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    logic [VEC_W-1:0] v;
    case (idx)
      2'd3:    v = 16'h0024;
      2'd2:    v = 16'h003C;
      2'd1:    v = 16'h0034;
      default: v = 16'h002C;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/irqvec_capture.sv
module irqvec_capture
  import irqvec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINE-1:0] irq_in,
  input  logic             ack_valid,
  input  logic [IDX_W-1:0] ack_idx,
  input  logic             clr_edge,
  output logic [NLINE-1:0] req_raw
);
  logic prev_urg_q, prev_edg_q, arm_q, urg_q, edg_q;
  logic arm_d, urg_d, edg_d;
  logic ack_urg, ack_edg, rise_edg;

  always_comb begin
    ack_urg  = ack_valid && (ack_idx == IDX_W'(IDX_URG));
    ack_edg  = ack_valid && (ack_idx == IDX_W'(IDX_EDG));
    rise_edg = irq_in[IDX_EDG] & ~prev_edg_q;
    arm_d    = irq_in[IDX_URG] & ~prev_urg_q;
    urg_d    = urg_q;
    if (ack_urg) urg_d = 1'b0;
    if (arm_q && irq_in[IDX_URG]) urg_d = 1'b1;
    edg_d    = edg_q;
    if (ack_edg || clr_edge) edg_d = 1'b0;
    if (rise_edg) edg_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_urg_q <= 1'b0;
      prev_edg_q <= 1'b0;
      arm_q      <= 1'b0;
      urg_q      <= 1'b0;
      edg_q      <= 1'b0;
    end else begin
      prev_urg_q <= irq_in[IDX_URG];
      prev_edg_q <= irq_in[IDX_EDG];
      arm_q      <= arm_d;
      urg_q      <= urg_d;
      edg_q      <= edg_d;
    end
  end

  assign req_raw = {urg_q, edg_q, irq_in[IDX_EDG-1:0]};
endmodule

// File: rtl/irqvec_ctrl_reg.sv
module irqvec_ctrl_reg
  import irqvec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [NMASK-1:0]  mask,
  output logic              glb_en,
  output logic              clr_edge
);
  logic [NMASK-1:0] mask_q, mask_d;
  logic             en_q, en_d;

  always_comb begin
    mask_d = mask_q;
    en_d   = en_q;
    if (reg_wr) begin
      mask_d = reg_wdata[NMASK-1:0];
      en_d   = reg_wdata[EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      en_q   <= 1'b0;
    end else begin
      mask_q <= mask_d;
      en_q   <= en_d;
    end
  end

  assign mask     = mask_q;
  assign glb_en   = en_q;
  assign clr_edge = reg_wr & reg_wdata[CLR_BIT];
endmodule

// File: rtl/irqvec_select.sv
module irqvec_select
  import irqvec_pkg::*;
(
  input  logic [NLINE-1:0] req_raw,
  input  logic [NMASK-1:0] mask,
  input  logic             glb_en,
  output logic             int_pend,
  output logic [VEC_W-1:0] vec_addr
);
  logic [NLINE-1:0] elig;

  for (genvar k = 0; k < NLINE; k++) begin : g_elig
    if (k == IDX_URG) begin : g_urg
      assign elig[k] = req_raw[k];
    end else begin : g_msk
      assign elig[k] = req_raw[k] & ~mask[k] & glb_en;
    end
  end

  always_comb begin
    logic [IDX_W-1:0] win;
    win = '0;
    for (int k = 0; k < NLINE; k++) begin
      if (elig[k]) win = IDX_W'(k);
    end
    int_pend = |elig;
    vec_addr = int_pend ? vec_of(win) : '0;
  end
endmodule

// File: rtl/irqvec_unit.sv
module irqvec_unit
  import irqvec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINE-1:0]  irq_in,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  input  logic              ack_valid,
  input  logic [IDX_W-1:0]  ack_idx,
  output logic              int_pend,
  output logic [VEC_W-1:0]  vec_addr
);
  logic [NLINE-1:0] req_raw;
  logic [NMASK-1:0] mask;
  logic             glb_en;
  logic             clr_edge;

  irqvec_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .mask(mask), .glb_en(glb_en), .clr_edge(clr_edge)
  );

  irqvec_capture u_cap (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_valid(ack_valid),
    .ack_idx(ack_idx), .clr_edge(clr_edge), .req_raw(req_raw)
  );

  irqvec_select u_sel (
    .req_raw(req_raw), .mask(mask), .glb_en(glb_en),
    .int_pend(int_pend), .vec_addr(vec_addr)
  );
endmodule

// File: rtl/irqvec_unit_chk.sv
module irqvec_unit_chk
  import irqvec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NLINE-1:0]  irq_in,
  input logic              reg_wr,
  input logic [CTRL_W-1:0] reg_wdata,
  input logic              ack_valid,
  input logic [IDX_W-1:0]  ack_idx,
  input logic              int_pend,
  input logic [VEC_W-1:0]  vec_addr,
  input logic [NLINE-1:0]  req_raw,
  input logic              glb_en
);
  // R4: a fresh urgent vector needs the line high at the two previous edges
  a_r4_urgent_filtered: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_addr == 16'h0024) |-> ($past(irq_in[3]) && $past(irq_in[3], 2)));

  // R3: a presented vector is one of the four fixed addresses
  a_r3_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
    int_pend |-> (vec_addr == 16'h0024 || vec_addr == 16'h003C ||
                  vec_addr == 16'h0034 || vec_addr == 16'h002C));

  // R11: idle output is zero
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !int_pend |-> (vec_addr == '0));

  // R5: an urgent latch is always presented
  a_r5_urgent_shown: assert property (@(posedge clk) disable iff (!rst_n)
    req_raw[3] |-> (int_pend && vec_addr == 16'h0024));

  // R9: global enable off leaves only the urgent line
  a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !req_raw[3]) |-> !int_pend);

  // R6: line 2 latch holds without a clear
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_raw[2] && !(ack_valid && ack_idx == 2'd2) && !(reg_wr && reg_wdata[4]))
      |=> req_raw[2]);

  // R10: acknowledge of line 3 clears it unless re-armed
  a_r10_ack_urg: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_idx == 2'd3 && !irq_in[3]) |=> !req_raw[3]);
endmodule

bind irqvec_unit irqvec_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .ack_valid(ack_valid), .ack_idx(ack_idx),
  .int_pend(int_pend), .vec_addr(vec_addr), .req_raw(req_raw), .glb_en(glb_en)
);

// File: tb/irqvec_unit_test.sv
module irqvec_unit_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 12;
  // {wdata[4:0], irq[1:0], exp_pend, exp_vec[15:0]}
  localparam logic [23:0] VECS [NVEC] = '{
    {5'h08, 2'b00, 1'b0, 16'h0000},
    {5'h08, 2'b01, 1'b1, 16'h002C},
    {5'h08, 2'b10, 1'b1, 16'h0034},
    {5'h08, 2'b11, 1'b1, 16'h0034},
    {5'h0A, 2'b11, 1'b1, 16'h002C},
    {5'h09, 2'b01, 1'b0, 16'h0000},
    {5'h0B, 2'b11, 1'b0, 16'h0000},
    {5'h00, 2'b11, 1'b0, 16'h0000},
    {5'h0C, 2'b11, 1'b1, 16'h0034},
    {5'h0E, 2'b11, 1'b1, 16'h002C},
    {5'h09, 2'b10, 1'b1, 16'h0034},
    {5'h08, 2'b01, 1'b1, 16'h002C}
  };

  logic        clk, rst_n, reg_wr, ack_valid, int_pend;
  logic [3:0]  irq_in;
  logic [4:0]  reg_wdata;
  logic [1:0]  ack_idx;
  logic [15:0] vec_addr;
  int n_chk, n_fail;
  bit done;

  irqvec_unit uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .ack_valid(ack_valid), .ack_idx(ack_idx),
    .int_pend(int_pend), .vec_addr(vec_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic ep, input logic [15:0] ev);
    n_chk++;
    if (int_pend !== ep || vec_addr !== ev) begin
      n_fail++;
      $display("FAIL %s: pend=%b vec=%h expected pend=%b vec=%h",
               req, int_pend, vec_addr, ep, ev);
    end
  endtask

  task automatic wr(input logic [4:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic ack(input logic [1:0] idx);
    ack_valid = 1'b1; ack_idx = idx;
    tick();
    ack_valid = 1'b0; ack_idx = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; irq_in = '0; reg_wr = 1'b0; reg_wdata = '0;
    ack_valid = 1'b0; ack_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    irq_in[1:0] = 2'b11;
    tick();
    chk("R1 reset state masks level lines", 1'b0, 16'h0000);

    // table walk: R2 R3 R7 R8 R9 R11
    for (int i = 0; i < NVEC; i++) begin
      wr(VECS[i][23:19]);
      irq_in[1:0] = VECS[i][18:17];
      #1;
      chk("R2/R3/R7/R8/R9/R11 table", VECS[i][16], VECS[i][15:0]);
    end

    // R4 glitch rejection
    irq_in = '0; wr(5'h07);
    irq_in[3] = 1'b1; @(posedge clk); @(negedge clk); irq_in[3] = 1'b0;
    tick(); tick();
    chk("R4 one-edge pulse discarded", 1'b0, 16'h0000);

    // R4/R5 valid urgent with everything masked and disabled
    irq_in[3] = 1'b1; tick();
    chk("R4 not yet after first edge", 1'b0, 16'h0000);
    tick();
    chk("R5 urgent ignores mask/enable", 1'b1, 16'h0024);

    // R2 urgent beats level lines
    wr(5'h08); irq_in[1:0] = 2'b11; #1;
    chk("R2 urgent above level lines", 1'b1, 16'h0024);
    ack(2'd1);
    chk("R10 ack other line keeps urgent", 1'b1, 16'h0024);
    ack(2'd3);
    chk("R10 ack line 3 clears it", 1'b1, 16'h0034);
    tick();
    chk("R4 held level does not re-trigger", 1'b1, 16'h0034);

    // line 2 edge latch while masked (R8)
    irq_in = '0; wr(5'h0C);
    irq_in[2] = 1'b1; tick(); irq_in[2] = 1'b0; tick();
    chk("R8 masked line 2 hidden", 1'b0, 16'h0000);
    wr(5'h08);
    chk("R8 latched edge shown after unmask", 1'b1, 16'h003C);
    irq_in[1:0] = 2'b11; #1;
    chk("R2 line 2 above line 1", 1'b1, 16'h003C);
    ack(2'd0);
    chk("R10 ack line 0 keeps line 2", 1'b1, 16'h003C);
    irq_in[1:0] = 2'b00;
    ack(2'd2);
    chk("R6 ack line 2 clears latch", 1'b0, 16'h0000);
    irq_in[2] = 1'b1; tick(); irq_in[2] = 1'b0; tick();
    chk("R6 line 2 held after input falls", 1'b1, 16'h003C);
    wr(5'h18);
    chk("R6 software clear of line 2", 1'b0, 16'h0000);
    irq_in[0] = 1'b1; #1;
    chk("R7 level line 0 follows input", 1'b1, 16'h002C);
    irq_in[0] = 1'b0; #1;
    chk("R7 level line 0 drops with input", 1'b0, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule